// File: doc/BRIEF.md
# Interval Bucket Calendar with Validity Filter

This block holds events that lie too far in the future for the on-chip priority queue. Each event carries a time tag, two bead IDs and the time it was created. The event's time tag picks one of a ring of buckets, and each bucket covers a fixed span of time. An insert appends the event at the tail of its bucket, so events inside a bucket stay unordered. Invalidations are never applied to stored events. Instead, a per-bead table records the most recent invalidation time of each bead.

When the on-chip queue needs more work, it raises a drain request. The block then reads the bucket at the ring head from end to end. An event is dropped if either of its beads was invalidated after the event was created. Each survivor is placed in a small insertion-sort buffer. After the whole bucket has been read, the sorted survivors are streamed out one per cycle, and the final one is marked. The bucket is then emptied and the head moves to the next bucket in the ring.

Top module: `bkc_calendar`

## Requirements
- R1: The bucket of an event is time tag bits [SHIFT +: BKT_LOG2], which equals (time >> SHIFT) mod NUM_BKT. After reset the head is bucket 0, and each completed drain advances the head by one around the ring.
- R2: The survivors of a drain are emitted in non-decreasing time-tag order. Events with equal tags keep their insertion order.
- R3: During a drain, an event is discarded when the recorded invalidation time of bead A or of bead B is strictly greater than its creation time. An equal time keeps the event. Every recorded invalidation time is 0 after reset, and an invalidation overwrites the bead's entry.
- R4: out_last is high on the final emitted element of a drain and on no other element.
- R5: An insert into a bucket that already holds DEPTH events is not stored and sets the sticky overflow output. The overflow output stays high until reset.
- R6: While a drain is in progress, an insert aimed at the head bucket is refused and sets overflow. Inserts aimed at other buckets are accepted.
- R7: A drain that finds no surviving events emits nothing and returns to idle. A drained bucket is empty afterwards.
- R8: After reset, busy, out_valid and overflow are 0.
- R9: busy rises in the cycle after a drain request is accepted in idle. With n events stored in the head bucket, the first element appears n+1 cycles after busy rises. The remaining elements follow on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert strobe |
| ins_time | input | TIME_W | Event time tag |
| ins_bead_a | input | BEAD_W | First bead of the event |
| ins_bead_b | input | BEAD_W | Second bead of the event |
| ins_ctime | input | TIME_W | Creation time of the event |
| inv_valid | input | 1 | Invalidation strobe |
| inv_bead | input | BEAD_W | Bead being invalidated |
| inv_time | input | TIME_W | Invalidation time |
| drain_req | input | 1 | Request to drain the head bucket |
| busy | output | 1 | A drain is in progress |
| out_valid | output | 1 | Sorted output element valid |
| out_time | output | TIME_W | Time tag of the output element |
| out_bead_a | output | BEAD_W | First bead of the output element |
| out_bead_b | output | BEAD_W | Second bead of the output element |
| out_last | output | 1 | Final element of this drain |
| overflow | output | 1 | Sticky flag for a refused insert |

## Verification
Each input pattern targets a different failure:
- A bucket loaded in descending order with repeated tags shows whether the sort is correct and whether it is stable.
- Invalidation times set just below, equal to and above the creation times show whether the stale filter uses strict or non-strict comparison, and whether it checks both beads.
- Several pseudo-random passes fill every bucket of the ring with counts from zero to full. Inserts land in random positions, so any error in bucket selection, head advance or bucket clearing shows up as wrong or missing events.
- Filling a bucket past capacity, and inserting into the head bucket during a drain, separate refused events from stored ones. An event that is wrongly stored appears in a later drain.

// File: rtl/bkc_pkg.sv
package bkc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EMIT = 2'd2
    } bkc_state_e;
endpackage

// File: rtl/bkc_bead_table.sv
// Per-bead record of the latest invalidation time, with a stale check for one event.
module bkc_bead_table #(
    parameter int BEAD_W = 3,
    parameter int TIME_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BEAD_W-1:0] wr_bead,
    input  logic [TIME_W-1:0] wr_time,
    input  logic [BEAD_W-1:0] chk_a,
    input  logic [BEAD_W-1:0] chk_b,
    input  logic [TIME_W-1:0] chk_ctime,
    output logic              stale
);
    localparam int NUM_BEAD = 1 << BEAD_W;

    logic [TIME_W-1:0] inv_d [NUM_BEAD];
    logic [TIME_W-1:0] inv_q [NUM_BEAD];

    always_comb begin
        inv_d = inv_q;
        if (wr_en) begin
            inv_d[wr_bead] = wr_time;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BEAD; i++) begin
                inv_q[i] <= '0;
            end
        end else begin
            inv_q <= inv_d;
        end
    end

    assign stale = (inv_q[chk_a] > chk_ctime) || (inv_q[chk_b] > chk_ctime);
endmodule

// File: rtl/bkc_sort_buf.sv
// Small insertion-sort buffer; equal keys stay in arrival order.
module bkc_sort_buf #(
    parameter int KEY_W = 12,
    parameter int PAY_W = 6,
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [KEY_W-1:0] push_key,
    input  logic [PAY_W-1:0] push_pay,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_key,
    output logic [PAY_W-1:0] rd_pay,
    output logic [CNT_W-1:0] count
);
    logic [KEY_W-1:0] key_d [DEPTH];
    logic [KEY_W-1:0] key_q [DEPTH];
    logic [PAY_W-1:0] pay_d [DEPTH];
    logic [PAY_W-1:0] pay_q [DEPTH];
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [DEPTH-1:0] not_after;
    logic [CNT_W-1:0] pos;

    // one comparator per slot: is this slot at or before the new key
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign not_after[g] = (CNT_W'(g) < cnt_q) && (key_q[g] <= push_key);
    end

    assign pos = CNT_W'($countones(not_after));

    always_comb begin
        key_d = key_q;
        pay_d = pay_q;
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (push) begin
            cnt_d = cnt_q + 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == pos) begin
                    key_d[IDX_W'(i)] = push_key;
                    pay_d[IDX_W'(i)] = push_pay;
                end else if (CNT_W'(i) > pos) begin
                    key_d[IDX_W'(i)] = key_q[IDX_W'((i > 0) ? i - 1 : 0)];
                    pay_d[IDX_W'(i)] = pay_q[IDX_W'((i > 0) ? i - 1 : 0)];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                key_q[i] <= '0;
                pay_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            key_q <= key_d;
            pay_q <= pay_d;
        end
    end

    assign rd_key = key_q[rd_idx];
    assign rd_pay = pay_q[rd_idx];
    assign count  = cnt_q;
endmodule

// File: rtl/bkc_calendar.sv
// Ring of unordered interval buckets, drained through a validity filter and a sort stage.
module bkc_calendar
    import bkc_pkg::*;
#(
    parameter int TIME_W   = 12,
    parameter int BEAD_W   = 3,
    parameter int BKT_LOG2 = 2,
    parameter int DEPTH    = 8,
    parameter int SHIFT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [TIME_W-1:0] ins_time,
    input  logic [BEAD_W-1:0] ins_bead_a,
    input  logic [BEAD_W-1:0] ins_bead_b,
    input  logic [TIME_W-1:0] ins_ctime,
    input  logic              inv_valid,
    input  logic [BEAD_W-1:0] inv_bead,
    input  logic [TIME_W-1:0] inv_time,
    input  logic              drain_req,
    output logic              busy,
    output logic              out_valid,
    output logic [TIME_W-1:0] out_time,
    output logic [BEAD_W-1:0] out_bead_a,
    output logic [BEAD_W-1:0] out_bead_b,
    output logic              out_last,
    output logic              overflow
);
    localparam int NUM_BKT = 1 << BKT_LOG2;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int PAY_W   = 2 * BEAD_W;

    typedef struct packed {
        logic [TIME_W-1:0] t;
        logic [BEAD_W-1:0] a;
        logic [BEAD_W-1:0] b;
        logic [TIME_W-1:0] ct;
    } evt_t;

    typedef struct {
        bkc_state_e          st;
        logic [BKT_LOG2-1:0] head;
        logic [CNT_W-1:0]    rd;
        logic [IDX_W-1:0]    em;
        logic                ovf;
        logic [CNT_W-1:0]    cnt [NUM_BKT];
        evt_t                mem [NUM_BKT][DEPTH];
    } ctl_t;

    ctl_t s_d, s_q;

    logic [BKT_LOG2-1:0] ins_bkt;
    evt_t                cur;
    logic                stale;
    logic                sb_clr, sb_push;
    logic [TIME_W-1:0]   sb_key;
    logic [PAY_W-1:0]    sb_pay;
    logic [CNT_W-1:0]    sb_cnt;
    logic                at_end, last_el;

    assign ins_bkt = ins_time[SHIFT +: BKT_LOG2];
    assign cur     = s_q.mem[s_q.head][IDX_W'(s_q.rd)];
    assign at_end  = (s_q.rd == s_q.cnt[s_q.head]);
    assign last_el = (CNT_W'(s_q.em) + CNT_W'(1)) == sb_cnt;

    bkc_bead_table #(.BEAD_W(BEAD_W), .TIME_W(TIME_W)) bead_tab_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (inv_valid),
        .wr_bead   (inv_bead),
        .wr_time   (inv_time),
        .chk_a     (cur.a),
        .chk_b     (cur.b),
        .chk_ctime (cur.ct),
        .stale     (stale)
    );

    bkc_sort_buf #(
        .KEY_W (TIME_W),
        .PAY_W (PAY_W),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) sort_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sb_clr),
        .push     (sb_push),
        .push_key (cur.t),
        .push_pay ({cur.a, cur.b}),
        .rd_idx   (s_q.em),
        .rd_key   (sb_key),
        .rd_pay   (sb_pay),
        .count    (sb_cnt)
    );

    always_comb begin
        s_d     = s_q;
        sb_clr  = 1'b0;
        sb_push = 1'b0;

        // append at bucket tail; refuse full bucket or the bucket under drain
        if (ins_valid) begin
            if ((s_q.cnt[ins_bkt] == CNT_W'(DEPTH)) ||
                ((s_q.st != ST_IDLE) && (ins_bkt == s_q.head))) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.mem[ins_bkt][IDX_W'(s_q.cnt[ins_bkt])] =
                    '{t: ins_time, a: ins_bead_a, b: ins_bead_b, ct: ins_ctime};
                s_d.cnt[ins_bkt] = s_q.cnt[ins_bkt] + 1'b1;
            end
        end

        unique case (s_q.st)
            ST_IDLE: begin
                if (drain_req) begin
                    s_d.st = ST_READ;
                    s_d.rd = '0;
                    sb_clr = 1'b1;
                end
            end
            ST_READ: begin
                if (at_end) begin
                    s_d.em = '0;
                    if (sb_cnt == '0) begin
                        s_d.st              = ST_IDLE;
                        s_d.cnt[s_q.head]   = '0;
                        s_d.head            = s_q.head + 1'b1;
                    end else begin
                        s_d.st = ST_EMIT;
                    end
                end else begin
                    sb_push = !stale;
                    s_d.rd  = s_q.rd + 1'b1;
                end
            end
            ST_EMIT: begin
                if (last_el) begin
                    s_d.st            = ST_IDLE;
                    s_d.cnt[s_q.head] = '0;
                    s_d.head          = s_q.head + 1'b1;
                    sb_clr            = 1'b1;
                end else begin
                    s_d.em = s_q.em + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.head <= '0;
            s_q.rd   <= '0;
            s_q.em   <= '0;
            s_q.ovf  <= 1'b0;
            for (int b = 0; b < NUM_BKT; b++) begin
                s_q.cnt[b] <= '0;
                for (int e = 0; e < DEPTH; e++) begin
                    s_q.mem[b][e] <= '0;
                end
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign busy                     = (s_q.st != ST_IDLE);
    assign out_valid                = (s_q.st == ST_EMIT);
    assign out_time                 = sb_key;
    assign {out_bead_a, out_bead_b} = sb_pay;
    assign out_last                 = out_valid && last_el;
    assign overflow                 = s_q.ovf;
endmodule

// File: rtl/bkc_checker.sv
module bkc_checker #(
    parameter int TIME_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drain_req,
    input logic              busy,
    input logic              out_valid,
    input logic              out_last,
    input logic              overflow,
    input logic [TIME_W-1:0] out_time
);
    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);                                          // R4
    AST_LAST_ENDS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);                                         // R4
    AST_STREAM_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && (out_time >= $past(out_time)))); // R2
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                           // R5
    AST_DRAIN_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && !busy) |=> busy);                                   // R9
    AST_OUTPUT_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);                                              // R7
endmodule

bind bkc_calendar bkc_checker #(.TIME_W(TIME_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .drain_req (drain_req),
    .busy      (busy),
    .out_valid (out_valid),
    .out_last  (out_last),
    .overflow  (overflow),
    .out_time  (out_time)
);

// File: tb/bkc_calendar_tb_top.sv
`timescale 1ns/1ps
module bkc_calendar_tb_top;
    localparam int TW = 12;
    localparam int BW = 3;
    localparam int BL = 2;
    localparam int NB = 4;
    localparam int DP = 8;
    localparam int SH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0;
    logic [TW-1:0] ins_time = '0;
    logic [BW-1:0] ins_bead_a = '0;
    logic [BW-1:0] ins_bead_b = '0;
    logic [TW-1:0] ins_ctime = '0;
    logic          inv_valid = 1'b0;
    logic [BW-1:0] inv_bead = '0;
    logic [TW-1:0] inv_time = '0;
    logic          drain_req = 1'b0;
    logic          busy, out_valid, out_last, overflow;
    logic [TW-1:0] out_time;
    logic [BW-1:0] out_bead_a, out_bead_b;

    always #2.5 clk = ~clk;

    bkc_calendar #(.TIME_W(TW), .BEAD_W(BW), .BKT_LOG2(BL), .DEPTH(DP), .SHIFT(SH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_time(ins_time),
        .ins_bead_a(ins_bead_a), .ins_bead_b(ins_bead_b), .ins_ctime(ins_ctime),
        .inv_valid(inv_valid), .inv_bead(inv_bead), .inv_time(inv_time),
        .drain_req(drain_req), .busy(busy), .out_valid(out_valid),
        .out_time(out_time), .out_bead_a(out_bead_a), .out_bead_b(out_bead_b),
        .out_last(out_last), .overflow(overflow)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int unsigned seed = 32'h1234_5678;

    int m_cnt [NB];
    int m_t   [NB][DP];
    int m_a   [NB][DP];
    int m_b   [NB][DP];
    int m_ct  [NB][DP];
    int b_inv [8];
    int m_head;
    bit m_ovf;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 16);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        ins_valid = 1'b0; inv_valid = 1'b0; drain_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int b = 0; b < NB; b++) m_cnt[b] = 0;
        for (int i = 0; i < 8; i++) b_inv[i] = 0;
        m_head = 0;
        m_ovf = 1'b0;
    endtask

    task automatic drive_ins(input int t, input int a, input int b, input int ct);
        ins_valid = 1'b1;
        ins_time = TW'(t); ins_bead_a = BW'(a); ins_bead_b = BW'(b); ins_ctime = TW'(ct);
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic ins(input int t, input int a, input int b, input int ct);
        int bk;
        bk = (t >> SH) % NB;
        if (m_cnt[bk] == DP) begin
            m_ovf = 1'b1;
        end else begin
            m_t[bk][m_cnt[bk]] = t; m_a[bk][m_cnt[bk]] = a;
            m_b[bk][m_cnt[bk]] = b; m_ct[bk][m_cnt[bk]] = ct;
            m_cnt[bk]++;
        end
        drive_ins(t, a, b, ct);
        chk(overflow == m_ovf, "R5", "overflow after insert", int'(overflow), int'(m_ovf));
    endtask

    task automatic inv(input int bead, input int t);
        inv_valid = 1'b1; inv_bead = BW'(bead); inv_time = TW'(t);
        @(negedge clk);
        inv_valid = 1'b0;
        b_inv[bead] = t;
    endtask

    task automatic drain();
        int h, n, ns, got, first;
        int s_t[DP]; int s_a[DP]; int s_b[DP];
        int e_t[DP]; int e_a[DP]; int e_b[DP];
        h = m_head; n = m_cnt[h]; ns = 0;
        for (int i = 0; i < n; i++) begin
            if (!(b_inv[m_a[h][i]] > m_ct[h][i] || b_inv[m_b[h][i]] > m_ct[h][i])) begin
                s_t[ns] = m_t[h][i]; s_a[ns] = m_a[h][i]; s_b[ns] = m_b[h][i]; ns++;
            end
        end
        for (int i = 0; i < ns; i++) begin
            int rk;
            rk = 0;
            for (int j = 0; j < ns; j++)
                if (s_t[j] < s_t[i] || (s_t[j] == s_t[i] && j < i)) rk++;
            e_t[rk] = s_t[i]; e_a[rk] = s_a[i]; e_b[rk] = s_b[i];
        end
        drain_req = 1'b1;
        @(negedge clk);
        drain_req = 1'b0;
        chk(busy == 1'b1, "R9", "busy after request", int'(busy), 1);
        got = 0; first = -1;
        for (int cyc = 0; cyc < 40 && busy; cyc++) begin
            if (out_valid) begin
                if (first < 0) first = cyc;
                if (got < ns) begin
                    chk(int'(out_time) == e_t[got], "R2", "time order", int'(out_time), e_t[got]);
                    chk(int'(out_bead_a) == e_a[got] && int'(out_bead_b) == e_b[got], "R2",
                        "bead pair (a*8+b)", int'(out_bead_a) * 8 + int'(out_bead_b),
                        e_a[got] * 8 + e_b[got]);
                    chk(out_last == (got == ns - 1), "R4", "last marker", int'(out_last),
                        int'(got == ns - 1));
                end
                got++;
            end
            @(negedge clk);
        end
        chk(got == ns, "R3", "survivor count", got, ns);
        if (ns > 0) chk(first == n + 1, "R9", "first element cycle", first, n + 1);
        chk(!busy, "R7", "idle after drain", int'(busy), 0);
        m_cnt[h] = 0;
        m_head = (h + 1) % NB;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int rcnt;
        do_reset();
        // R8 reset state
        chk(busy == 1'b0, "R8", "busy at reset", int'(busy), 0);
        chk(out_valid == 1'b0, "R8", "out_valid at reset", int'(out_valid), 0);
        chk(overflow == 1'b0, "R8", "overflow at reset", int'(overflow), 0);

        // R2/R4: descending with ties in bucket 0
        ins(14, 1, 2, 0); ins(3, 3, 4, 0); ins(9, 5, 6, 0);
        ins(3, 7, 0, 0); ins(0, 2, 3, 0); ins(14, 4, 5, 0);
        drain();

        // R3: stale filter boundaries in bucket 1
        inv(2, 50);
        ins(20, 2, 5, 49); ins(21, 6, 2, 50); ins(22, 1, 3, 10);
        ins(23, 7, 0, 4); ins(24, 0, 7, 5);
        inv(7, 5);
        drain();

        // R7: empty buckets 2 and 3
        drain();
        drain();

        // R1: pseudo-random sweep over the ring, several passes
        for (int p = 1; p <= 4; p++) begin
            for (int b = 0; b < NB; b++) begin
                int n;
                n = (p * 3 + b) % 9;
                for (int i = 0; i < n; i++) begin
                    if (p >= 3 && i == 0) inv(rnd() % 8, rnd() % 128);
                    ins(p * 64 + b * 16 + rnd() % 16, rnd() % 8, rnd() % 8, rnd() % 128);
                end
                chk(m_head == b, "R1", "ring position", m_head, b);
                drain();
            end
        end

        // R5: full bucket
        do_reset();
        for (int i = 0; i < DP; i++) ins(15 - i, i, 7 - i, 0);
        chk(overflow == 1'b0, "R5", "no overflow at capacity", int'(overflow), 0);
        ins(1, 1, 1, 0);
        chk(overflow == 1'b1, "R5", "overflow past capacity", int'(overflow), 1);
        drain();

        // R6: inserts during a drain
        do_reset();
        ins(5, 1, 2, 0); ins(2, 3, 4, 0); ins(8, 5, 6, 0);
        drain_req = 1'b1;
        @(negedge clk);
        drain_req = 1'b0;
        rcnt = 0;
        drive_ins(16 + 5, 2, 2, 0);
        chk(overflow == 1'b0, "R6", "other bucket accepted", int'(overflow), 0);
        if (out_valid) rcnt++;
        drive_ins(7, 3, 3, 0);
        chk(overflow == 1'b1, "R6", "head bucket refused", int'(overflow), 1);
        for (int cyc = 0; cyc < 40 && busy; cyc++) begin
            if (out_valid) rcnt++;
            @(negedge clk);
        end
        chk(rcnt == 3, "R6", "drained count", rcnt, 3);
        m_cnt[0] = 0; m_head = 1; m_ovf = 1'b1;
        m_t[1][0] = 21; m_a[1][0] = 2; m_b[1][0] = 2; m_ct[1][0] = 0; m_cnt[1] = 1;
        drain();
        drain();
        drain();
        drain();   // bucket 0 again: refused event must be absent (R6)

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule